// File: doc/BRIEF.md
# MSI-X Vector Table and Pending-Bit Controller

This block keeps a table of message-signalled interrupt vectors, one slot per vector, together with a pending-bit array. Software reaches both through a register port that takes 4-byte and 8-byte accesses. Each table slot holds a 64-bit message address, a 32-bit message data word and a control word. Bit 0 of the control word is the vector's mask.

Device logic raises per-vector interrupt requests. A request on an unmasked vector is turned into an outgoing message, made of the slot's address and data, on a valid/ready output. A request on a masked vector is not dropped. It is parked as a pending bit. When software later clears that vector's mask while the bit is pending, the block sends the deferred message and clears the bit. Deliveries that are due at the same time are kept as per-vector dispatch flags. They leave one at a time, lowest vector first, so a request that collides with an unmask-triggered delivery is never lost.

The sender is a two-state machine. In `ST_IDLE`, the *launch* transition is taken when some unmasked vector has its dispatch flag set. It copies that vector's current address and data into the output registers and moves to `ST_SEND`. In `ST_SEND` the message is offered, and the *accept* transition back to `ST_IDLE` is taken in the cycle `msg_ready` is high.

Top module: `msix_ctrl`

## Requirements
- R1: After reset every vector is masked (control bit 0 reads 1), all address and data words read 0, every pending bit is 0 and `msg_valid` is low.
- R2: With `reg_pba`=0, the slot index is the byte offset divided by 16. Within a slot, byte offsets 0, 4, 8 and 12 hold the address low word, the address high word, the data word and the control word. A 4-byte access (`reg_size`=2) returns its word in bits 31:0.
- R3: An 8-byte access (`reg_size`=3) is little-endian. At slot offset 0 it covers {address high, address low}. At slot offset 8 it covers {control, data}, and a write there updates both the data word and the mask.
- R4: Only bit 0 of the control word is stored (1 = masked). The other control bits read as 0.
- R5: A request on an unmasked vector produces one message carrying {address high, address low} and the data word of that slot.
- R6: A request on a masked vector emits nothing and sets its pending bit. With `reg_pba`=1, the bit for vector v is bit (v mod 64) of the 64-bit word at byte offset 8*(v div 64). A 4-byte read at offset +4 returns that word's upper half.
- R7: A write that turns a vector's mask from 1 to 0 while its pending bit is 1 produces that vector's message, using the slot's address and data after the write, and clears the pending bit.
- R8: Writes with `reg_pba`=1 change no state.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold their values.
- R10: Deliveries due together are all sent, lowest vector index first. Repeated requests for a vector whose message has not yet been launched yield a single message.
- R11: A size code other than 2 or 3, a misaligned offset, or a slot index at or beyond the number of vectors reads 0 and changes no state.
- R12: A pending bit is only ever held by a masked vector. Masking a vector whose message is due but not yet launched moves that delivery into its pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_pba | input | 1 | 1 selects the pending-bit window, 0 the vector table |
| reg_ofs | input | 16 | Byte offset within the selected window |
| reg_size | input | 2 | Access size code: 2 = 4 bytes, 3 = 8 bytes |
| reg_wdata | input | 64 | Write data (4-byte writes use bits 31:0) |
| reg_rdata | output | 64 | Read data for the addressed location (combinational) |
| irq_req | input | 8 | Per-vector interrupt request pulses |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The hardest case to reach is a collision in one clock edge: an unmask write that flushes a pending vector, a fresh request on another vector, and a message already stalled by backpressure. The bench builds it by holding `msg_ready` low and then driving the control-word write and the request pulses in the same cycle. It then releases `msg_ready` and expects the messages in index order. A second stall keeps a dispatched vector waiting while software masks it. The pending-bit window has to show the parked bit, and the message must appear only after a later unmask.

// File: rtl/msix_pkg.sv
package msix_pkg;
    typedef enum logic [0:0] {
        ST_IDLE,
        ST_SEND
    } send_state_e;

    localparam logic [1:0] SZ_W4 = 2'd2;
    localparam logic [1:0] SZ_W8 = 2'd3;

    localparam logic [1:0] POS_ALO = 2'd0;
    localparam logic [1:0] POS_AHI = 2'd1;
    localparam logic [1:0] POS_DAT = 2'd2;
    localparam logic [1:0] POS_CTL = 2'd3;
endpackage

// File: rtl/msix_entry_bank.sv
module msix_entry_bank
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int OFS_W   = 16,
    parameter int IDX_W   = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [OFS_W-1:0]   ofs,
    input  logic [1:0]         size,
    input  logic [63:0]        wdata,
    output logic [63:0]        rdata,
    input  logic [IDX_W-1:0]   sel_idx,
    output logic [63:0]        sel_addr,
    output logic [31:0]        sel_data,
    output logic [NUM_VEC-1:0] mask,
    output logic [NUM_VEC-1:0] mask_clr,
    output logic [NUM_VEC-1:0] mask_set
);
    localparam int ENT_W = OFS_W - 4;

    logic [31:0] alo [NUM_VEC];
    logic [31:0] ahi [NUM_VEC];
    logic [31:0] dat [NUM_VEC];

    logic [ENT_W-1:0] ent;
    logic [IDX_W-1:0] eidx;
    logic [1:0]       pos;
    logic             in_range, ok4, ok8, acc_ok, ctl_hit, new_bit;

    assign ent      = ofs[OFS_W-1:4];
    assign eidx     = IDX_W'(ent);
    assign pos      = ofs[3:2];
    assign in_range = {1'b0, ent} < (ENT_W+1)'(NUM_VEC);
    assign ok4      = (size == SZ_W4) && (ofs[1:0] == 2'b00);
    assign ok8      = (size == SZ_W8) && (ofs[2:0] == 3'b000);
    assign acc_ok   = in_range && (ok4 || ok8);
    assign ctl_hit  = wr_en && acc_ok && ((ok4 && pos == POS_CTL) || (ok8 && pos == POS_DAT));
    assign new_bit  = ok4 ? wdata[0] : wdata[32];

    always_comb begin
        for (int v = 0; v < NUM_VEC; v++) begin
            mask_clr[v] = ctl_hit && (eidx == IDX_W'(v)) && mask[v] && !new_bit;
            mask_set[v] = ctl_hit && (eidx == IDX_W'(v)) && !mask[v] && new_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask <= '1;
        else        mask <= (mask & ~mask_clr) | mask_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NUM_VEC; v++) begin
                alo[v] <= '0;
                ahi[v] <= '0;
                dat[v] <= '0;
            end
        end else if (wr_en && acc_ok) begin
            if (ok4) begin
                unique case (pos)
                    POS_ALO: alo[eidx] <= wdata[31:0];
                    POS_AHI: ahi[eidx] <= wdata[31:0];
                    POS_DAT: dat[eidx] <= wdata[31:0];
                    POS_CTL: ;
                endcase
            end else if (pos == POS_ALO) begin
                alo[eidx] <= wdata[31:0];
                ahi[eidx] <= wdata[63:32];
            end else begin
                dat[eidx] <= wdata[31:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (acc_ok) begin
            if (ok4) begin
                unique case (pos)
                    POS_ALO: rdata = {32'b0, alo[eidx]};
                    POS_AHI: rdata = {32'b0, ahi[eidx]};
                    POS_DAT: rdata = {32'b0, dat[eidx]};
                    POS_CTL: rdata = {63'b0, mask[eidx]};
                endcase
            end else if (pos == POS_ALO) begin
                rdata = {ahi[eidx], alo[eidx]};
            end else begin
                rdata = {31'b0, mask[eidx], dat[eidx]};
            end
        end
    end

    assign sel_addr = {ahi[sel_idx], alo[sel_idx]};
    assign sel_data = dat[sel_idx];
endmodule

// File: rtl/msix_pend_track.sv
module msix_pend_track
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int OFS_W   = 16,
    parameter int IDX_W   = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] req,
    input  logic [NUM_VEC-1:0] mask,
    input  logic [NUM_VEC-1:0] mask_clr,
    input  logic [NUM_VEC-1:0] mask_set,
    input  logic               grant,
    input  logic [IDX_W-1:0]   grant_idx,
    input  logic [OFS_W-1:0]   ofs,
    input  logic [1:0]         size,
    output logic [63:0]        pba_rdata,
    output logic [NUM_VEC-1:0] eligible
);
    localparam int PBA_WORDS = (NUM_VEC + 63) / 64;
    localparam int PBA_W     = PBA_WORDS * 64;
    localparam int WI_W      = OFS_W - 3;

    logic [NUM_VEC-1:0] pend, disp, m_new, hit, gmask, disp_keep, fresh;
    logic [PBA_W-1:0]   pad;
    logic [WI_W-1:0]    widx;
    logic [63:0]        word;

    assign m_new     = (mask & ~mask_clr) | mask_set;
    assign hit       = pend | (req & mask);
    assign gmask     = grant ? (NUM_VEC'(1) << grant_idx) : '0;
    assign disp_keep = disp & ~gmask;
    assign fresh     = req & ~mask;
    assign eligible  = disp & ~mask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            disp <= '0;
        end else begin
            disp <= (disp_keep | fresh | (mask_clr & hit)) & ~m_new;
            pend <= (hit & ~mask_clr) | ((disp_keep | fresh) & m_new);
        end
    end

    assign pad  = PBA_W'(pend);
    assign widx = ofs[OFS_W-1:3];

    always_comb begin
        word = '0;
        for (int w = 0; w < PBA_WORDS; w++)
            if (widx == WI_W'(w)) word = pad[w*64 +: 64];
        pba_rdata = '0;
        if (size == SZ_W8 && ofs[2:0] == 3'b000)
            pba_rdata = word;
        else if (size == SZ_W4 && ofs[1:0] == 2'b00)
            pba_rdata = {32'b0, ofs[2] ? word[63:32] : word[31:0]};
    end

    assert_pend_only_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~mask) == '0);

    assert_grant_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> !mask[grant_idx]);

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec_chk
        assert_masked_req_parks_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (req[v] && mask[v] && !mask_clr[v]) |=> pend[v]);
        assert_unmask_flushes_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_clr[v] && pend[v]) |=> (!pend[v] && disp[v]));
    end
endmodule

// File: rtl/msix_send_fsm.sv
module msix_send_fsm
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int IDX_W   = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] eligible,
    input  logic [63:0]        sel_addr,
    input  logic [31:0]        sel_data,
    output logic               grant,
    output logic [IDX_W-1:0]   grant_idx,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data
);
    send_state_e state, state_nx;

    always_comb begin
        grant_idx = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--)
            if (eligible[i]) grant_idx = IDX_W'(i);
    end

    always_comb begin
        state_nx = state;
        grant    = 1'b0;
        unique case (state)
            ST_IDLE: if (|eligible) begin
                grant    = 1'b1;
                state_nx = ST_SEND;
            end
            ST_SEND: if (msg_ready) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_addr <= '0;
            msg_data <= '0;
        end else if (grant) begin
            msg_addr <= sel_addr;
            msg_data <= sel_data;
        end
    end

    assign msg_valid = (state == ST_SEND);

    assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
endmodule

// File: rtl/msix_ctrl.sv
module msix_ctrl
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int OFS_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_pba,
    input  logic [OFS_W-1:0]   reg_ofs,
    input  logic [1:0]         reg_size,
    input  logic [63:0]        reg_wdata,
    output logic [63:0]        reg_rdata,
    input  logic [NUM_VEC-1:0] irq_req,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data
);
    localparam int IDX_W = $clog2(NUM_VEC);

    logic [63:0]        tbl_rdata, pba_rdata, sel_addr;
    logic [31:0]        sel_data;
    logic [NUM_VEC-1:0] mask, mask_clr, mask_set, eligible;
    logic               grant;
    logic [IDX_W-1:0]   grant_idx;

    msix_entry_bank #(.NUM_VEC(NUM_VEC), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && !reg_pba), .ofs(reg_ofs),
        .size(reg_size), .wdata(reg_wdata), .rdata(tbl_rdata), .sel_idx(grant_idx),
        .sel_addr(sel_addr), .sel_data(sel_data), .mask(mask),
        .mask_clr(mask_clr), .mask_set(mask_set)
    );

    msix_pend_track #(.NUM_VEC(NUM_VEC), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .req(irq_req), .mask(mask), .mask_clr(mask_clr),
        .mask_set(mask_set), .grant(grant), .grant_idx(grant_idx), .ofs(reg_ofs),
        .size(reg_size), .pba_rdata(pba_rdata), .eligible(eligible)
    );

    msix_send_fsm #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .eligible(eligible), .sel_addr(sel_addr),
        .sel_data(sel_data), .grant(grant), .grant_idx(grant_idx),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
        .msg_data(msg_data)
    );

    assign reg_rdata = reg_pba ? pba_rdata : tbl_rdata;
endmodule

// File: tb/msix_ctrl_test.sv
module msix_ctrl_test;
    localparam int NV = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_pba = 1'b0;
    logic [15:0]   reg_ofs = '0;
    logic [1:0]    reg_size = 2'd2;
    logic [63:0]   reg_wdata = '0, reg_rdata;
    logic [NV-1:0] irq_req = '0;
    logic          msg_valid, msg_ready = 1'b1;
    logic [63:0]   msg_addr;
    logic [31:0]   msg_data;

    int checks = 0, fails = 0;
    logic [95:0] exp_q[$];
    logic        stalled = 1'b0;
    logic [95:0] held;

    always #5 clk = ~clk;

    msix_ctrl uut (.*);

    function automatic logic [63:0] vaddr(int v);
        return {32'(v), 32'hFEE0_0000 + 32'(v * 16)};
    endfunction
    function automatic logic [31:0] vdata(int v);
        return 32'h4000 + 32'(v);
    endfunction

    task automatic chk(string tag, logic [95:0] act, logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(logic pba, logic [15:0] ofs, logic [1:0] sz, logic [63:0] d);
        step();
        reg_wr = 1'b1; reg_pba = pba; reg_ofs = ofs; reg_size = sz; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(string tag, logic pba, logic [15:0] ofs, logic [1:0] sz, logic [63:0] exp);
        step();
        reg_pba = pba; reg_ofs = ofs; reg_size = sz;
        #1;
        chk(tag, {32'b0, reg_rdata}, {32'b0, exp});
    endtask

    task automatic pulse(logic [NV-1:0] v);
        step();
        irq_req = v;
        step();
        irq_req = '0;
    endtask

    task automatic expect_msg(int v, logic [31:0] d);
        exp_q.push_back({vaddr(v), d});
    endtask

    task automatic drain(string tag);
        int n = 0;
        while ((exp_q.size() != 0 || msg_valid) && n < 300) begin
            step();
            n++;
        end
        repeat (6) step();
        chk(tag, 96'(exp_q.size()), 96'd0);
    endtask

    // monitor: scoreboard pop and stall stability (R9)
    always @(negedge clk) begin
        if (rst_n) begin
            if (stalled && msg_valid) chk("R9 held message", {msg_addr, msg_data}, held);
            else if (stalled)         chk("R9 valid dropped", 96'd0, 96'd1);
            if (msg_valid && msg_ready) begin
                if (exp_q.size() == 0) chk("R5 unexpected message", {msg_addr, msg_data}, 96'd0);
                else chk("R5/R10 message order", {msg_addr, msg_data}, exp_q.pop_front());
            end
            stalled = msg_valid && !msg_ready;
            held    = {msg_addr, msg_data};
        end
    end

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset state
        rd("R1 slot0 addr", 0, 16'h0000, 2'd3, 64'h0);
        rd("R1 slot0 ctl/data", 0, 16'h0008, 2'd3, 64'h1_0000_0000);
        rd("R1 slot7 ctl", 0, 16'h007C, 2'd2, 64'h1);
        rd("R1 pba", 1, 16'h0000, 2'd3, 64'h0);
        chk("R1 msg_valid", 96'(msg_valid), 96'd0);

        // R2 4-byte programming of slot 0, R3 8-byte for slots 1..3
        wr(0, 16'h0000, 2'd2, {32'b0, vaddr(0)[31:0]});
        wr(0, 16'h0004, 2'd2, {32'b0, vaddr(0)[63:32]});
        wr(0, 16'h0008, 2'd2, {32'b0, vdata(0)});
        for (int v = 1; v < 4; v++) begin
            wr(0, 16'(v * 16), 2'd3, vaddr(v));
            wr(0, 16'(v * 16 + 8), 2'd3, {32'h1, vdata(v)});
        end
        rd("R2 slot0 addr lo", 0, 16'h0000, 2'd2, {32'b0, vaddr(0)[31:0]});
        rd("R2 slot1 addr hi", 0, 16'h0014, 2'd2, 64'h1);
        rd("R2 slot3 data", 0, 16'h0038, 2'd2, {32'b0, vdata(3)});
        rd("R3 slot2 addr 8B", 0, 16'h0020, 2'd3, vaddr(2));
        rd("R3 slot2 ctl/data 8B", 0, 16'h0028, 2'd3, {32'h1, vdata(2)});

        // R4 only bit 0 of control kept
        wr(0, 16'h003C, 2'd2, 64'hFFFF_FFFE);
        rd("R4 ctl other bits", 0, 16'h003C, 2'd2, 64'h0);
        wr(0, 16'h003C, 2'd2, 64'hFFFF_FFFF);
        rd("R4 ctl mask bit", 0, 16'h003C, 2'd2, 64'h1);

        // R6 masked request parks
        pulse(8'b0000_0010);
        repeat (6) step();
        rd("R6 pba word", 1, 16'h0000, 2'd3, 64'h2);
        rd("R6 pba upper half", 1, 16'h0004, 2'd2, 64'h0);

        // R8 pba writes ignored
        wr(1, 16'h0000, 2'd3, '1);
        rd("R8 pba unchanged", 1, 16'h0000, 2'd3, 64'h2);

        // R7 unmask flushes pending
        expect_msg(1, vdata(1));
        wr(0, 16'h001C, 2'd2, 64'h0);
        drain("R7 flush sent");
        rd("R7 pba cleared", 1, 16'h0000, 2'd3, 64'h0);

        // R5 direct delivery
        expect_msg(1, vdata(1));
        pulse(8'b0000_0010);
        drain("R5 direct sent");

        // R3/R7 8-byte write updates data and unmasks
        pulse(8'b0000_0100);
        repeat (4) step();
        expect_msg(2, 32'h5555);
        wr(0, 16'h0028, 2'd3, {32'h0, 32'h5555});
        drain("R7 8B unmask sent");
        rd("R3 data updated", 0, 16'h0028, 2'd3, {32'h0, 32'h5555});

        // R10 collision under backpressure
        wr(0, 16'h000C, 2'd2, 64'h0);
        pulse(8'b0000_1000);
        step();
        msg_ready = 1'b0;
        expect_msg(0, vdata(0));
        expect_msg(1, vdata(1));
        expect_msg(3, vdata(3));
        step();
        reg_wr = 1'b1; reg_pba = 0; reg_ofs = 16'h003C; reg_size = 2'd2; reg_wdata = 64'h0;
        irq_req = 8'b0000_0011;
        step();
        reg_wr = 1'b0;
        irq_req = '0;
        repeat (3) step();
        pulse(8'b0000_0010);
        repeat (4) step();
        msg_ready = 1'b1;
        drain("R10 all delivered");

        // R12 masking a dispatched vector parks it
        step();
        msg_ready = 1'b0;
        expect_msg(0, vdata(0));
        pulse(8'b0000_0011);
        repeat (2) step();
        wr(0, 16'h001C, 2'd2, 64'h1);
        repeat (3) step();
        msg_ready = 1'b1;
        drain("R12 only slot0 sent");
        rd("R12 pba parked", 1, 16'h0000, 2'd3, 64'h2);
        expect_msg(1, vdata(1));
        wr(0, 16'h001C, 2'd2, 64'h0);
        drain("R12 parked later sent");

        // R11 unsupported accesses
        wr(0, 16'h0080, 2'd2, 64'hDEAD);
        rd("R11 out of range read", 0, 16'h0080, 2'd2, 64'h0);
        rd("R11 no alias write", 0, 16'h0000, 2'd2, {32'b0, vaddr(0)[31:0]});
        wr(0, 16'h0008, 2'd1, 64'hBEEF);
        rd("R11 bad size no write", 0, 16'h0008, 2'd2, {32'b0, vdata(0)});
        rd("R11 bad size read", 0, 16'h0008, 2'd1, 64'h0);
        rd("R11 misaligned read", 0, 16'h0002, 2'd2, 64'h0);

        repeat (5) step();
        chk("R10 queue empty", 96'(exp_q.size()), 96'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule